// File: doc/BRIEF.md
# Baud Tick and Character Timeout Generator

This block is the timing core of a UART. It divides the UART input clock by a programmable divisor to produce the oversampling tick. Each tick marks one quarter of a bit, so four ticks make one bit time. Software loads the divisor as the input clock frequency divided by four times the baud rate. A read-only frequency word reports the input clock rate, so that driver code can compute that divisor.

The same tick stream measures a receive character timeout in whole bit times. While the receive FIFO holds data and no new character arrives or is read, the block counts bit times. It raises a single-cycle pulse for the interrupt logic once the programmed number of bit times has elapsed. The block also holds the line-control fields that set the frame format (word length, stop bits, parity) and the modem-control output bits. These drive the serial shifters and pin logic, which lie outside this block.

Registers are reached through a word-indexed port with a two-bit index. Writes are synchronous. Reads are combinational from the index.

Top module: `uart_tick_gen`

## Requirements
- R1: After reset the configuration word reads 0, every frame-format and modem output is 0, `charTimeout` is 0, and the divisor and timeout registers read 0.
- R2: With divisor D ≥ 1 in register index 2 (bits D-width-1:0), `baudTick` is a one-cycle pulse that repeats every D clock cycles.
- R3: A divisor of 0 behaves as a divisor of 1, so `baudTick` is high on every cycle.
- R4: A write to the divisor register restarts the tick phase: the first tick is D cycles after the write edge.
- R5: Index 1 reads the input clock frequency `UART_CLK_HZ` (default 29,491,200). Writes to index 1 are ignored.
- R6: In the configuration word (index 0), bits 9:8 are the word-length code (0 = 5 bits up to 3 = 8 bits), bit 10 selects two stop bits, bit 11 enables parity, and bit 12 selects even parity when 1 and odd parity when 0. These bits drive the matching outputs and read back unchanged.
- R7: Configuration bits 24 through 29 drive `dtr`, `rts`, `out1`, `out2`, `loopback` and `autoFlow`, in that order. All other configuration bits read as 0.
- R8: With timeout value T ≥ 1 in index 3 and `rxNonEmpty` held high, `charTimeout` pulses for one cycle, in the cycle after the 4·T-th `baudTick` that follows the last reload.
- R9: A pulse on `rxEvent` reloads the timeout count, and so does a write to the timeout register. A tick that arrives in the same cycle as a reload is not counted.
- R10: Ticks that arrive while `rxNonEmpty` is low are not counted. The count is held, not cleared.
- R11: A timeout value of 0 disables the timeout, so `charTimeout` stays low.
- R12: After a pulse, no further pulse occurs until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index: 0 config, 1 frequency, 2 divisor, 3 timeout |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| rxEvent | input | 1 | Pulse when a character is received or the RX FIFO is read |
| rxNonEmpty | input | 1 | RX FIFO holds data |
| baudTick | output | 1 | Quarter-bit oversampling tick |
| charTimeout | output | 1 | One-cycle character timeout pulse |
| wordLen | output | 2 | Word-length code |
| twoStop | output | 1 | Two stop bits |
| parityEn | output | 1 | Parity enabled |
| parityEven | output | 1 | Even parity when 1 |
| dtr | output | 1 | Modem control: data terminal ready |
| rts | output | 1 | Modem control: request to send |
| out1 | output | 1 | General modem output 1 |
| out2 | output | 1 | General modem output 2 |
| loopback | output | 1 | Loopback mode |
| autoFlow | output | 1 | Automatic hardware flow control |

## Verification
The assertions check four properties on every cycle:
- Ticks never fall on adjacent cycles unless the effective divisor is 1.
- A zero divisor gives a tick every cycle.
- The timeout pulse is never longer than one cycle, and it never appears while the timeout is disabled or after a cycle with an empty FIFO.
- A divisor write lands in the register.

Exact counts need the bench's scenarios: the first-tick latency and the tick period over a sweep of divisors, and the exact timeout cycle for several divisor and timeout pairs. The bench also covers a gated FIFO-nonempty pattern, a mid-count reload, and the register readback and bit placement.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_FREQ = 2'd1;
  localparam logic [1:0] REG_DIV  = 2'd2;
  localparam logic [1:0] REG_TMO  = 2'd3;

  // Bit placement inside the configuration word
  localparam int FRAME_LSB = 8;
  localparam int MODEM_LSB = 24;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDiv;    // divisor register written this cycle
    logic reloadTmo;  // restart the character timeout count
  } tickStrobe_t;

  // Frame format, MSB first so that bit 0 lands on config bit 8
  typedef struct packed {
    logic       parityEven;
    logic       parityEn;
    logic       twoStop;
    logic [1:0] wordLen;
  } frameFmt_t;

  // Modem control, MSB first so that bit 0 lands on config bit 24
  typedef struct packed {
    logic autoFlow;
    logic loopback;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } modemCtl_t;

endpackage

// File: rtl/uart_tick_ctrl.sv
module uart_tick_ctrl
  import uart_tick_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int TO_W       = 16,
  parameter int UART_CLK_HZ = 29491200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              rxEvent,
  output tickStrobe_t       strobe,
  output logic [DIV_W-1:0]  divReg,
  output logic [TO_W-1:0]   tmoReg,
  output frameFmt_t         frame,
  output modemCtl_t         modem
);

  localparam int FRAME_W = $bits(frameFmt_t);
  localparam int MODEM_W = $bits(modemCtl_t);
  localparam logic [31:0] FREQ_WORD = 32'(UART_CLK_HZ);

  logic wrCfg, wrDiv, wrTmo;
  logic unusedWrBits;

  assign wrCfg = regWrEn && (regAddr == REG_CFG);
  assign wrDiv = regWrEn && (regAddr == REG_DIV);
  assign wrTmo = regWrEn && (regAddr == REG_TMO);

  assign unusedWrBits = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame  <= '0;
      modem  <= '0;
      divReg <= '0;
      tmoReg <= '0;
    end else begin
      if (wrCfg) begin
        frame <= regWrData[FRAME_LSB +: FRAME_W];
        modem <= regWrData[MODEM_LSB +: MODEM_W];
      end
      if (wrDiv) divReg <= regWrData[DIV_W-1:0];
      if (wrTmo) tmoReg <= regWrData[TO_W-1:0];
    end
  end

  always_comb begin
    strobe.loadDiv   = wrDiv;
    strobe.reloadTmo = wrTmo || rxEvent;
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_CFG: begin
        regRdData[FRAME_LSB +: FRAME_W] = frame;
        regRdData[MODEM_LSB +: MODEM_W] = modem;
      end
      REG_FREQ: regRdData = FREQ_WORD;
      REG_DIV:  regRdData[DIV_W-1:0] = divReg;
      REG_TMO:  regRdData[TO_W-1:0] = tmoReg;
      default:  regRdData = '0;
    endcase
  end

  // R4: a divisor write lands in the register on the following cycle
  p_div_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_DIV) |=> (divReg == $past(regWrData[DIV_W-1:0])));

endmodule

// File: rtl/uart_tick_datapath.sv
module uart_tick_datapath
  import uart_tick_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int TO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobe_t       strobe,
  input  logic [DIV_W-1:0]  divReg,
  input  logic [TO_W-1:0]   tmoReg,
  input  logic              rxNonEmpty,
  output logic              tick,
  output logic              timeoutPulse
);

  localparam int TICKS_PER_BIT_LOG2 = 2;
  localparam int TGT_W = TO_W + TICKS_PER_BIT_LOG2;

  // ---------------- divider ----------------
  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] divCnt;

  assign effDiv = (divReg == '0) ? DIV_W'(1) : divReg;
  assign tick   = (divCnt >= effDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divCnt <= '0;
    else if (strobe.loadDiv) divCnt <= '0;
    else if (tick)           divCnt <= '0;
    else                     divCnt <= divCnt + DIV_W'(1);
  end

  // ---------------- character timeout ----------------
  logic [TGT_W-1:0] target;
  logic [TGT_W-1:0] targetM1;
  logic [TGT_W-1:0] tickCnt;
  logic             fired;
  logic             countOn;

  assign target   = {tmoReg, {TICKS_PER_BIT_LOG2{1'b0}}};
  assign targetM1 = target - TGT_W'(1);
  assign countOn  = tick && rxNonEmpty && (tmoReg != '0) && !fired;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt      <= '0;
      fired        <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= 1'b0;
      if (strobe.reloadTmo) begin
        tickCnt <= '0;
        fired   <= 1'b0;
      end else if (countOn) begin
        if (tickCnt == targetM1) begin
          tickCnt      <= '0;
          fired        <= 1'b1;
          timeoutPulse <= 1'b1;
        end else begin
          tickCnt <= tickCnt + TGT_W'(1);
        end
      end
    end
  end

  // R2: ticks are isolated unless the effective divisor is one
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && effDiv > DIV_W'(1) && !strobe.loadDiv) |=> !tick);

  // R3: a zero divisor ticks every cycle
  p_div_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (divReg == '0 && !strobe.loadDiv) |=> tick);

  // R12: the timeout is a single-cycle pulse
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  // R11: disabled timeout never pulses
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    (tmoReg == '0) |-> !timeoutPulse);

  // R10: no pulse follows a cycle with an empty FIFO
  p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxNonEmpty) |-> !timeoutPulse);

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
  import uart_tick_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int TO_W        = 16,
  parameter int UART_CLK_HZ = 29491200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        rxEvent,
  input  logic        rxNonEmpty,
  output logic        baudTick,
  output logic        charTimeout,
  output logic [1:0]  wordLen,
  output logic        twoStop,
  output logic        parityEn,
  output logic        parityEven,
  output logic        dtr,
  output logic        rts,
  output logic        out1,
  output logic        out2,
  output logic        loopback,
  output logic        autoFlow
);

  tickStrobe_t      strobe;
  logic [DIV_W-1:0] divReg;
  logic [TO_W-1:0]  tmoReg;
  frameFmt_t        frame;
  modemCtl_t        modem;

  uart_tick_ctrl #(
    .DIV_W(DIV_W), .TO_W(TO_W), .UART_CLK_HZ(UART_CLK_HZ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rxEvent(rxEvent),
    .strobe(strobe), .divReg(divReg), .tmoReg(tmoReg),
    .frame(frame), .modem(modem)
  );

  uart_tick_datapath #(
    .DIV_W(DIV_W), .TO_W(TO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .divReg(divReg), .tmoReg(tmoReg),
    .rxNonEmpty(rxNonEmpty),
    .tick(baudTick), .timeoutPulse(charTimeout)
  );

  assign wordLen    = frame.wordLen;
  assign twoStop    = frame.twoStop;
  assign parityEn   = frame.parityEn;
  assign parityEven = frame.parityEven;
  assign dtr        = modem.dtr;
  assign rts        = modem.rts;
  assign out1       = modem.out1;
  assign out2       = modem.out2;
  assign loopback   = modem.loopback;
  assign autoFlow   = modem.autoFlow;

endmodule

// File: tb/tb_uart_tick_gen.sv
`timescale 1ns/1ps
module tb_uart_tick_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rxEvent = 1'b0;
  logic        rxNonEmpty = 1'b0;
  logic        baudTick, charTimeout;
  logic [1:0]  wordLen;
  logic        twoStop, parityEn, parityEven;
  logic        dtr, rts, out1, out2, loopback, autoFlow;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  uart_tick_gen dut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rxEvent(rxEvent), .rxNonEmpty(rxNonEmpty),
    .baudTick(baudTick), .charTimeout(charTimeout),
    .wordLen(wordLen), .twoStop(twoStop), .parityEn(parityEn),
    .parityEven(parityEven), .dtr(dtr), .rts(rts), .out1(out1),
    .out2(out2), .loopback(loopback), .autoFlow(autoFlow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Checks first-tick latency and two following periods after a divisor write
  task automatic checkTick(input int div, input string req);
    int eff = (div == 0) ? 1 : div;
    int ticks[3];
    int n = 0;
    wr(2'd2, 32'(div));
    for (int idx = 1; idx <= 3 * eff + 6; idx++) begin
      if (baudTick && n < 3) begin ticks[n] = idx; n++; end
      @(negedge clk);
    end
    chk(n == 3, req, n, 3);
    chk(ticks[0] == eff, req, ticks[0], eff);
    chk(ticks[1] - ticks[0] == eff && ticks[2] - ticks[1] == eff, req,
        ticks[2] - ticks[1], eff);
  endtask

  // Runs one timeout scenario and compares the pulse cycle against a tick count
  task automatic runTmo(input int div, input int t, input bit gated,
                        input int reloadAt, input string req);
    int eff = (div == 0) ? 1 : div;
    int window = 12 * t * eff + 80;
    int cnt = 0;
    int expIdx = -1;
    int firstIdx = -1;
    int npulse = 0;
    bit ne;
    wr(2'd2, 32'(div));
    wr(2'd3, 32'(t));
    rxEvent = 1'b1;
    @(negedge clk);
    rxEvent = 1'b0;
    for (int idx = 1; idx <= window; idx++) begin
      ne = gated ? (idx % 3 != 0) : 1'b1;
      rxNonEmpty = ne;
      rxEvent = (idx == reloadAt);
      if (charTimeout) begin
        npulse++;
        if (firstIdx < 0) firstIdx = idx;
      end
      if (idx == reloadAt) cnt = 0;
      else if (baudTick && ne && expIdx < 0 && t != 0) begin
        cnt++;
        if (cnt == 4 * t) expIdx = idx + 1;
      end
      @(negedge clk);
    end
    rxEvent = 1'b0;
    rxNonEmpty = 1'b0;
    if (t == 0) chk(npulse == 0, req, npulse, 0);
    else begin
      chk(firstIdx == expIdx, req, firstIdx, expIdx);
      chk(npulse == 1, "R12", npulse, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    chk(charTimeout == 1'b0, "R1", charTimeout, 0);
    chk({wordLen, twoStop, parityEn, parityEven, dtr, rts, out1, out2, loopback, autoFlow} == '0,
        "R1", {wordLen, twoStop, parityEn, parityEven, dtr, rts, out1, out2, loopback, autoFlow}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk(v == 0, "R1", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", v, 0);
    rd(2'd3, v); chk(v == 0, "R1", v, 0);
    chk(baudTick == 1'b1, "R3", baudTick, 1);

    // R5 frequency word, read-only
    rd(2'd1, v); chk(v == 32'd29491200, "R5", v, 29491200);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); chk(v == 32'd29491200, "R5", v, 29491200);

    // R6 frame fields, swept over all 32 combinations
    for (int f = 0; f < 32; f++) begin
      wr(2'd0, 32'(f) << 8);
      chk(wordLen == 2'(f) && twoStop == f[2] && parityEn == f[3] && parityEven == f[4],
          "R6", {parityEven, parityEn, twoStop, wordLen}, f);
      rd(2'd0, v); chk(v == (32'(f) << 8), "R6", v, 32'(f) << 8);
    end

    // R7 modem bits, one at a time, and reserved bits read zero
    for (int b = 0; b < 6; b++) begin
      wr(2'd0, 32'h1 << (24 + b));
      chk({autoFlow, loopback, out2, out1, rts, dtr} == 6'(1 << b), "R7",
          {autoFlow, loopback, out2, out1, rts, dtr}, 1 << b);
    end
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'h3F00_1F00, "R7", v, 32'h3F00_1F00);
    wr(2'd0, 32'h0);

    // R2 / R3 / R4 divisor sweep
    checkTick(0, "R3");
    for (int d = 1; d <= 7; d++) checkTick(d, "R2");
    checkTick(3, "R4");
    checkTick(1, "R4");
    rd(2'd2, v); chk(v == 1, "R4", v, 1);

    // R8 timeout sweep with the FIFO held nonempty
    for (int d = 1; d <= 3; d++)
      for (int t = 1; t <= 3; t++)
        runTmo(d, t, 1'b0, -1, "R8");
    runTmo(0, 2, 1'b0, -1, "R3");
    // R10 gated nonempty
    runTmo(2, 2, 1'b1, -1, "R10");
    runTmo(1, 3, 1'b1, -1, "R10");
    // R9 mid-count reload
    runTmo(2, 3, 1'b0, 10, "R9");
    runTmo(1, 2, 1'b1, 5, "R9");
    // R11 disabled
    runTmo(1, 0, 1'b0, -1, "R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule